// File: doc/BRIEF.md
# Synchronous Burst SRAM Access Front End

This block is the clocked control front end of a word-wide synchronous SRAM split into four byte lanes. On each rising clock edge it looks at two competing active-low address strobes (a processor-side strobe and a controller-side strobe), three chip enables, write controls and an advance signal. From these it decides whether a new external address is captured, whether the device is selected, and whether the current access reads a word or writes a masked set of byte lanes.

An access keeps going after its address is captured. Each later cycle with no strobe continues the same access. Holding advance low steps the two low address bits through a four-beat burst, in linear or interleaved order. Read data is registered, so it shows at the outputs one edge after the cycle that read it. The output enable is combinational. It is held off for the first read after the device has been deselected.

The bidirectional data bus is modelled as three signals: a separate input word, an output word and an output-drive flag. The storage array is an inferred register array of 2^ADDR_W words.

Top module: `ssram_front`

## Requirements
- R1: An edge with `adsp_n` low and `ce1_n` low, or with `adsc_n` low, captures `addr` as the new access address. The low two bits start the burst at beat zero.
- R2: When both strobes are low and `ce1_n` is low, the processor strobe is the one acted on. At such an edge the write controls are ignored and the old access performs a read. An edge loaded by the controller strobe alone honours the write controls for the old access.
- R3: While `ce1_n` is high the processor strobe is ignored. With `adsc_n` high no address loads and the access continues. With `adsc_n` low the controller strobe loads and deselects the device.
- R4: The device is selected when `ce1_n`=0, `ce2`=1 and `ce3_n`=0. The enables are sampled only at load edges; changing them on other edges has no effect.
- R5: With `gw_n` low, a write edge of a selected access writes all four lanes, whatever `bwe_n` and `bsel_n` hold.
- R6: With `gw_n` high and `bwe_n` low, only the lanes g whose `bsel_n[g]` is low are written; lane g is bits [8g+7:8g]. With both `gw_n` and `bwe_n` high, nothing is written and `bsel_n` is ignored.
- R7: At an edge with no load and `adv_n` low, the burst beat count advances by one, modulo 4. The low address bits are start+count mod 4 when `burst_linear`=1, and start XOR count when `burst_linear`=0. With `adv_n` high the address holds.
- R8: Each edge of a selected access with no lane written reads the current access address. After that edge `dout` holds the word and `rd_valid` is 1. Any other edge leaves `rd_valid` at 0.
- R9: `dq_drive` = !`oe_n` AND `rd_valid` AND not-masked, and it follows `oe_n` within the cycle. The first read after any edge spent deselected (reset included) is masked.
- R10: A synchronous active-low reset leaves the device deselected with `rd_valid` and `dq_drive` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| adsp_n | input | 1 | Processor address strobe, active low |
| adsc_n | input | 1 | Controller address strobe, active low |
| ce1_n | input | 1 | Chip enable 1, active low; also gates the processor strobe |
| ce2 | input | 1 | Chip enable 2, active high |
| ce3_n | input | 1 | Chip enable 3, active low |
| addr | input | ADDR_W | External word address |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write, all lanes, active low |
| bwe_n | input | 1 | Byte write enable, active low |
| bsel_n | input | LANES | Per-lane byte select, active low |
| oe_n | input | 1 | Output enable, active low, combinational |
| burst_linear | input | 1 | 1 = linear burst order, 0 = interleaved |
| din | input | LANES*LANE_W | Write data |
| dout | output | LANES*LANE_W | Registered read data |
| rd_valid | output | 1 | dout holds data read at the last edge |
| dq_drive | output | 1 | Data bus drive enable |

## Verification
On every cycle the assertions check several rules. Select state moves only at load edges. A controller load with chip enable 1 high deselects. A load puts the presented address into the access address, and an advance adds one beat. Read-valid never follows a write or an unselected edge, and the masked first read never repeats on the next cycle. Lane contents, strobe priority under write controls, linear and interleaved beat orders, and the mask after re-selection are shown only by the bench scenarios. There, a behavioural model is compared on every clock against data words that were written beforehand.

// File: rtl/ssram_pkg.sv
// Shared definitions for the synchronous SRAM front end.
// Assumes a four-beat burst, so the burst counter is always two bits wide.
package ssram_pkg;

    localparam int unsigned BURST_BITS = 2;

    // Low address bits of a burst beat, for either beat order.
    function automatic logic [BURST_BITS-1:0] burst_low(
        input logic                  linear,
        input logic [BURST_BITS-1:0] start,
        input logic [BURST_BITS-1:0] beat
    );
        if (linear) begin
            burst_low = BURST_BITS'(start + beat);
        end else begin
            burst_low = start ^ beat;
        end
    endfunction

endpackage

// File: rtl/ssram_strobe_ctl.sv
// Strobe arbitration and select state.
// Decides which address strobe acts on this edge and keeps the select flag.
// The processor strobe wins when both are low, and it is ignored while
// chip enable 1 is high. The chip enables are sampled only on load edges.
module ssram_strobe_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic adsp_n,
    input  logic adsc_n,
    input  logic ce1_n,
    input  logic ce2,
    input  logic ce3_n,
    output logic load,
    output logic proc_load,
    output logic sel_q
);

    logic ctl_load;
    logic ce_ok;

    // Strobe priority: the processor strobe counts only when chip enable 1 is low.
    always_comb begin
        proc_load = !adsp_n && !ce1_n;
        ctl_load  = !adsc_n && !proc_load;
        load      = proc_load || ctl_load;
        ce_ok     = !ce1_n && ce2 && !ce3_n;
    end

    // Select flag: updated from the chip enables only on load edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= 1'b0;
        end else if (load) begin
            sel_q <= ce_ok;
        end
    end

    AST_SEL_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(sel_q)); // R4

    AST_PROC_GATED_BY_CE1: assert property (@(posedge clk) disable iff (!rst_n)
        (ce1_n && adsc_n) |=> $stable(sel_q)); // R3

    AST_CTL_DESELECTS: assert property (@(posedge clk) disable iff (!rst_n)
        (ce1_n && !adsc_n) |=> !sel_q); // R3

endmodule

// File: rtl/ssram_burst_addr.sv
// Access address register with a four-beat burst counter.
// A load captures the external address and restarts the count at zero.
// On other edges a low advance input steps the count.
// The beat order is chosen by the burst_linear input.
module ssram_burst_addr #(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              adv_n,
    input  logic              burst_linear,
    output logic [ADDR_W-1:0] acc_addr
);
    import ssram_pkg::*;

    logic [ADDR_W-1:BURST_BITS] base_q;
    logic [BURST_BITS-1:0]      start_q;
    logic [BURST_BITS-1:0]      beat_q;

    // Base and start capture on load; the beat counter steps on advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            start_q <= '0;
            beat_q  <= '0;
        end else if (load) begin
            base_q  <= addr_in[ADDR_W-1:BURST_BITS];
            start_q <= addr_in[BURST_BITS-1:0];
            beat_q  <= '0;
        end else if (!adv_n) begin
            beat_q  <= BURST_BITS'(beat_q + 1'b1);
        end
    end

    // Current access address: upper bits fixed, low bits from the beat order.
    always_comb begin
        acc_addr = {base_q, burst_low(burst_linear, start_q, beat_q)};
    end

    AST_LOAD_TAKES_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (acc_addr == $past(addr_in))); // R1

    AST_ADV_STEPS_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !adv_n) |=> (beat_q == BURST_BITS'($past(beat_q) + 1'b1))); // R7

    AST_HOLD_WITHOUT_ADV: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && adv_n) |=> $stable(beat_q)); // R7

endmodule

// File: rtl/ssram_lane_dec.sv
// Byte-lane write enable decode.
// A global write sets every lane; otherwise the byte write enable passes the
// active-low lane selects. Suppress forces all lanes off, for processor-strobe
// edges, where write controls are ignored.
module ssram_lane_dec #(
    parameter int unsigned LANES = 4
) (
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] bsel_n,
    input  logic             suppress,
    output logic [LANES-1:0] lane_we
);

    // One enable per lane, built the same way for each.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_we[g] = !suppress && (!gw_n || (!bwe_n && !bsel_n[g]));
    end

endmodule

// File: rtl/ssram_store.sv
// Storage array and registered read path.
// A selected edge with any lane enabled writes those lanes at the access
// address. A selected edge with no lane enabled reads that address into the
// output register. The first read after a deselected edge is flagged so the
// output drive can be held off for that cycle.
module ssram_store #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned LANES  = 4,
    parameter int unsigned LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sel,
    input  logic [LANES-1:0]        lane_we,
    input  logic [ADDR_W-1:0]       acc_addr,
    input  logic [LANES*LANE_W-1:0] din,
    output logic [LANES*LANE_W-1:0] dout,
    output logic                    rd_valid,
    output logic                    first_rd
);

    localparam int unsigned DEPTH  = 1 << ADDR_W;
    localparam int unsigned DATA_W = LANES * LANE_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic              rd_now;
    logic              desel_seen_q;

    // A read happens on a selected edge that writes no lane.
    always_comb begin
        rd_now = sel && (lane_we == '0);
    end

    // Array write: only the enabled lanes of the access word change.
    always_ff @(posedge clk) begin
        if (sel) begin
            for (int l = 0; l < LANES; l++) begin
                if (lane_we[l]) begin
                    mem[acc_addr][l*LANE_W +: LANE_W] <= din[l*LANE_W +: LANE_W];
                end
            end
        end
    end

    // Read register, valid flag and the first-read-after-deselect mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout         <= '0;
            rd_valid     <= 1'b0;
            first_rd     <= 1'b0;
            desel_seen_q <= 1'b1;
        end else begin
            rd_valid <= rd_now;
            first_rd <= rd_now && desel_seen_q;
            if (rd_now) begin
                dout <= mem[acc_addr];
            end
            if (!sel) begin
                desel_seen_q <= 1'b1;
            end else if (rd_now) begin
                desel_seen_q <= 1'b0;
            end
        end
    end

    AST_VALID_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> !rd_valid); // R8

    AST_WRITE_NOT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && (lane_we != '0)) |=> !rd_valid); // R6

    AST_MASK_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        first_rd |=> !first_rd); // R9

endmodule

// File: rtl/ssram_front.sv
// Synchronous burst SRAM access front end, top level.
// Joins strobe arbitration, the burst address register, lane decode and the
// storage array. The data bus is split into din, dout and a drive enable.
// Output enable is combinational and is gated by the read-valid and
// first-read mask flags.
module ssram_front #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned LANES  = 4,
    parameter int unsigned LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    adsp_n,
    input  logic                    adsc_n,
    input  logic                    ce1_n,
    input  logic                    ce2,
    input  logic                    ce3_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    adv_n,
    input  logic                    gw_n,
    input  logic                    bwe_n,
    input  logic [LANES-1:0]        bsel_n,
    input  logic                    oe_n,
    input  logic                    burst_linear,
    input  logic [LANES*LANE_W-1:0] din,
    output logic [LANES*LANE_W-1:0] dout,
    output logic                    rd_valid,
    output logic                    dq_drive
);

    logic              load;
    logic              proc_load;
    logic              sel_q;
    logic [ADDR_W-1:0] acc_addr;
    logic [LANES-1:0]  lane_we;
    logic              first_rd;

    ssram_strobe_ctl u_strobe (
        .clk       (clk),
        .rst_n     (rst_n),
        .adsp_n    (adsp_n),
        .adsc_n    (adsc_n),
        .ce1_n     (ce1_n),
        .ce2       (ce2),
        .ce3_n     (ce3_n),
        .load      (load),
        .proc_load (proc_load),
        .sel_q     (sel_q)
    );

    ssram_burst_addr #(.ADDR_W(ADDR_W)) u_burst (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (load),
        .addr_in      (addr),
        .adv_n        (adv_n),
        .burst_linear (burst_linear),
        .acc_addr     (acc_addr)
    );

    ssram_lane_dec #(.LANES(LANES)) u_lanes (
        .gw_n     (gw_n),
        .bwe_n    (bwe_n),
        .bsel_n   (bsel_n),
        .suppress (proc_load),
        .lane_we  (lane_we)
    );

    ssram_store #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (sel_q),
        .lane_we  (lane_we),
        .acc_addr (acc_addr),
        .din      (din),
        .dout     (dout),
        .rd_valid (rd_valid),
        .first_rd (first_rd)
    );

    // Bus drive: output enable qualified by valid data outside the masked read.
    always_comb begin
        dq_drive = !oe_n && rd_valid && !first_rd;
    end

    AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!rd_valid && !dq_drive)); // R10

    AST_DRIVE_NEEDS_OE: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dq_drive); // R9

endmodule

// File: tb/ssram_front_test.sv
// Bench for ssram_front: a behavioural per-clock model, compared at each
// falling edge, plus directed checks against known data words.
module ssram_front_test;

    localparam int AW = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        adsp_n = 1'b1, adsc_n = 1'b1;
    logic        ce1_n = 1'b0, ce2 = 1'b1, ce3_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic        adv_n = 1'b1, gw_n = 1'b1, bwe_n = 1'b1;
    logic [3:0]  bsel_n = 4'hF;
    logic        oe_n = 1'b0, burst_linear = 1'b1;
    logic [31:0] din = '0;
    logic [31:0] dout;
    logic        rd_valid, dq_drive;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R10";
    bit    done = 1'b0;

    // model state
    logic [31:0] m_mem [256];
    logic [31:0] m_dout = '0;
    bit   m_sel = 0, m_valid = 0, m_first = 0, m_pdes = 1;
    int   m_base = 0, m_start = 0, m_cnt = 0;

    always #4 clk = ~clk;

    ssram_front #(.ADDR_W(AW), .LANES(4), .LANE_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .adsp_n(adsp_n), .adsc_n(adsc_n),
        .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .addr(addr), .adv_n(adv_n),
        .gw_n(gw_n), .bwe_n(bwe_n), .bsel_n(bsel_n), .oe_n(oe_n),
        .burst_linear(burst_linear), .din(din), .dout(dout),
        .rd_valid(rd_valid), .dq_drive(dq_drive)
    );

    // Behavioural reference, one update per rising edge.
    always @(posedge clk) begin
        bit   pl, cl, ld;
        logic [3:0] we;
        int   low, a;
        if (!rst_n) begin
            m_sel = 0; m_valid = 0; m_first = 0; m_pdes = 1;
            m_base = 0; m_start = 0; m_cnt = 0;
        end else begin
            pl = !adsp_n && !ce1_n;
            cl = !adsc_n && !pl;
            ld = pl || cl;
            if (!gw_n) we = 4'hF;
            else if (!bwe_n) we = ~bsel_n;
            else we = 4'h0;
            if (pl) we = 4'h0;
            low = burst_linear ? ((m_start + m_cnt) % 4) : (m_start ^ m_cnt);
            a = (m_base & ~3) | low;
            if (m_sel && we != 0) begin
                for (int l = 0; l < 4; l++)
                    if (we[l]) m_mem[a][l*8 +: 8] = din[l*8 +: 8];
                m_valid = 0; m_first = 0;
            end else if (m_sel) begin
                m_dout = m_mem[a]; m_valid = 1; m_first = m_pdes; m_pdes = 0;
            end else begin
                m_valid = 0; m_first = 0; m_pdes = 1;
            end
            if (ld) begin
                m_base = int'(addr); m_start = int'(addr) % 4; m_cnt = 0;
                m_sel = !ce1_n && ce2 && !ce3_n;
            end else if (!adv_n) begin
                m_cnt = (m_cnt + 1) % 4;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Compare ports with the model (called away from the rising edge).
    task automatic compare();
        chk({cur_req, " valid"}, 32'(rd_valid), 32'(m_valid));
        chk({cur_req, " drive"}, 32'(dq_drive), 32'(!oe_n && m_valid && !m_first));
        if (m_valid) chk({cur_req, " data"}, dout, m_dout);
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic idle();
        adsp_n = 1; adsc_n = 1; ce1_n = 0; ce2 = 1; ce3_n = 0;
        adv_n = 1; gw_n = 1; bwe_n = 1; bsel_n = 4'hF; oe_n = 0;
    endtask

    function automatic logic [31:0] dw(input int i);
        return 32'hA0C0_0000 + 32'(i) * 32'h0101_1111;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        tick(); tick();
        // R10: reset state
        chk("R10 valid", 32'(rd_valid), 0);
        chk("R10 drive", 32'(dq_drive), 0);
        rst_n = 1;

        // R5: global-write burst fill of 0x20..0x23 (controller load)
        cur_req = "R5";
        idle(); adsc_n = 0; addr = 8'h20; tick();
        idle(); gw_n = 0; adv_n = 0; bwe_n = 0; bsel_n = 4'hF;
        for (int i = 0; i < 4; i++) begin
            din = dw(i); tick();
            chk("R5 no valid on write", 32'(rd_valid), 0);
        end

        // R1/R9: processor load; that edge reads old access 0x20, masked
        cur_req = "R1";
        idle(); adsp_n = 0; addr = 8'h22; tick();
        chk("R9 masked first read data", dout, dw(0));
        chk("R9 masked first read drive", 32'(dq_drive), 0);
        idle(); tick();
        chk("R8 read of loaded address", dout, dw(2));
        chk("R8 drive on second read", 32'(dq_drive), 1);
        oe_n = 1; #1;
        chk("R9 drive follows oe", 32'(dq_drive), 0);
        oe_n = 0; #1;

        // R7: linear burst 2,3,0,1
        cur_req = "R7";
        adv_n = 0;
        tick(); chk("R7 lin beat0", dout, dw(2));
        tick(); chk("R7 lin beat1", dout, dw(3));
        tick(); chk("R7 lin wrap", dout, dw(0));
        tick(); chk("R7 lin beat3", dout, dw(1));

        // R7: interleaved burst from 1: 1,0,3,2
        idle(); burst_linear = 0; adsp_n = 0; addr = 8'h21; tick();
        idle(); adv_n = 0;
        tick(); chk("R7 ilv beat0", dout, dw(1));
        tick(); chk("R7 ilv beat1", dout, dw(0));
        tick(); chk("R7 ilv beat2", dout, dw(3));
        tick(); chk("R7 ilv beat3", dout, dw(2));

        // R6: byte write lanes 0 and 2, then selects ignored without bwe
        cur_req = "R6";
        idle(); adsc_n = 0; addr = 8'h30; tick();
        idle(); burst_linear = 1; gw_n = 0; din = 32'h1122_3344; tick();
        idle(); bwe_n = 0; bsel_n = 4'b1010; din = 32'hAABB_CCDD; tick();
        idle(); bsel_n = 4'h0; din = 32'hFFFF_FFFF; tick();
        chk("R6 lane mask and ignored selects", dout, 32'h11BB_33DD);

        // R2: both strobes with global write: no write
        cur_req = "R2";
        idle(); adsp_n = 0; adsc_n = 0; addr = 8'h30; gw_n = 0; din = 32'h0; tick();
        idle(); tick();
        chk("R2 processor edge ignores write", dout, 32'h11BB_33DD);
        idle(); adsc_n = 0; addr = 8'h30; gw_n = 0; din = 32'h0000_0055; tick();
        idle(); tick();
        chk("R2 controller edge writes", dout, 32'h0000_0055);

        // R3: processor strobe ignored with ce1 high; controller deselects
        cur_req = "R3";
        idle(); ce1_n = 1; adsp_n = 0; addr = 8'h20; tick();
        chk("R3 ignored strobe keeps access", dout, 32'h0000_0055);
        chk("R3 still valid", 32'(rd_valid), 1);
        idle(); ce1_n = 1; adsc_n = 0; tick();
        idle(); tick();
        chk("R3 deselected no valid", 32'(rd_valid), 0);

        // R4/R9: enables without strobe do not select; reselect masks
        cur_req = "R4";
        idle(); tick();
        chk("R4 enables not sampled", 32'(rd_valid), 0);
        idle(); adsc_n = 0; addr = 8'h20; tick();
        cur_req = "R9";
        idle(); tick();
        chk("R9 mask after reselect", 32'(dq_drive), 0);
        chk("R9 data after reselect", dout, dw(0));
        cur_req = "R4";
        idle(); ce2 = 0; tick();
        chk("R4 ce2 change ignored", 32'(rd_valid), 1);
        chk("R4 drive after ce2 change", 32'(dq_drive), 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule